// File: doc/BRIEF.md
# BCD counter ASCII line streamer

The block keeps a decimal counter as packed BCD digits and sends every counter value to a byte-wide FIFO as one line of text. A line is the digits written out as zero-padded ASCII characters, most significant digit first, followed by a newline byte. After the newline byte has been written the counter advances by one, so each line carries a new value. When every digit is 9 the counter wraps to all zeros.

Bytes leave over a simple write handshake. An active-low input reports that the FIFO has room. The block raises a write strobe for one clock with the byte on the data bus, then drops the strobe for at least one clock before it writes again. A read strobe output is tied inactive because the block never reads the FIFO. An 8-bit status output shows the two most significant BCD digits of the counter. Each digit takes one nibble. All state starts from a synchronous active-high reset.

Top module: `bcd_line_streamer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `wr` = 0, `status` = 0x00 and `data` = 0x30, and the next line carries the value zero.
- R2: A line is DIGITS+1 bytes long. It is the DIGITS digit characters followed by the newline byte 0x0A.
- R3: The first byte of a line is the most significant decimal digit, and the remaining digits follow in falling significance.
- R4: Each digit byte is 0x30 plus the BCD digit value (0..9 maps to 0x30..0x39), and the counter is zero-padded to the full DIGITS characters.
- R5: `wr` rises only when `txe_n` was low at the preceding clock edge. `wr` stays high for exactly one cycle per byte, with that byte on `data`, and then stays low for at least one cycle.
- R6: If `wr` is low and `txe_n` is low at a clock edge, `wr` is high in the next cycle.
- R7: `rd_n` is 1 in every cycle.
- R8: The counter advances by exactly one at the clock edge that ends the newline strobe, and it holds its value at all other times.
- R9: The counter counts in BCD. A carry moves into the next digit only when a digit rolls from 9 to 0, and all nines wrap to all zeros.
- R10: `status` holds the two most significant BCD digits. The most significant digit is in bits 7:4 and the next one is in bits 3:0.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txe_n | input | 1 | FIFO has room, active low |
| wr | output | 1 | Write strobe, one cycle per byte |
| rd_n | output | 1 | Read strobe, always inactive (1) |
| data | output | 8 | Byte being written |
| status | output | 8 | Top two BCD digits of the counter |

## Verification
The handshake properties assume that `txe_n` is a clean, synchronous level that is stable around each rising edge. They also assume that the FIFO takes a byte whenever `wr` is high, so a byte is never refused after its strobe. The bench changes `txe_n` only on falling edges. It uses three patterns: held low, pseudo-random, and long blocked stretches. It follows a 2-digit configuration through more than two full wraps. Every byte is compared with text computed from the number of lines completed so far.

// File: rtl/bcd_line_streamer.sv
module bcd_line_streamer #(
  parameter int DIGITS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txe_n,
  output logic       wr,
  output logic       rd_n,
  output logic [7:0] data,
  output logic [7:0] status
);
  localparam int CW = 4 * DIGITS;
  localparam int PW = $clog2(DIGITS + 1);
  localparam logic [PW-1:0] LAST = PW'(DIGITS);

  logic [CW-1:0] count, count_inc;
  logic [PW-1:0] pos;
  logic [DIGITS:0] carry;
  logic [3:0] cur_digit;
  logic last;

  function automatic logic [7:0] to_ascii(input logic [3:0] d);
    case (d)
      4'd0: to_ascii = 8'h30;
      4'd1: to_ascii = 8'h31;
      4'd2: to_ascii = 8'h32;
      4'd3: to_ascii = 8'h33;
      4'd4: to_ascii = 8'h34;
      4'd5: to_ascii = 8'h35;
      4'd6: to_ascii = 8'h36;
      4'd7: to_ascii = 8'h37;
      4'd8: to_ascii = 8'h38;
      4'd9: to_ascii = 8'h39;
      default: to_ascii = 8'h3F;
    endcase
  endfunction

  assign carry[0] = 1'b1;
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] d;
    logic nine;
    assign d = count[4*i +: 4];
    assign nine = (d == 4'd9);
    assign carry[i+1] = carry[i] & nine;
    assign count_inc[4*i +: 4] = !carry[i] ? d : (nine ? 4'd0 : d + 4'd1);
  end

  always_comb begin
    cur_digit = 4'd0;
    for (int i = 0; i < DIGITS; i++)
      if (int'(pos) == i) cur_digit = count[4*(DIGITS-1-i) +: 4];
  end

  assign last   = (pos == LAST);
  assign data   = last ? 8'h0A : to_ascii(cur_digit);
  assign rd_n   = 1'b1;
  assign status = count[CW-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr    <= 1'b0;
      pos   <= '0;
      count <= '0;
    end else if (wr) begin
      wr <= 1'b0;
      if (last) begin
        pos   <= '0;
        count <= count_inc;
      end else begin
        pos <= pos + 1'b1;
      end
    end else if (!txe_n) begin
      wr <= 1'b1;
    end
  end
endmodule

module bcd_line_streamer_chk #(
  parameter int DIGITS = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       txe_n,
  input logic       wr,
  input logic       rd_n,
  input logic [7:0] data,
  input logic [7:0] status
);
  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst) wr |=> !wr);
  // R5
  strobe_blocked_chk: assert property (@(posedge clk) disable iff (rst) (!wr && txe_n) |=> !wr);
  // R6
  strobe_ready_chk: assert property (@(posedge clk) disable iff (rst) (!wr && !txe_n) |=> wr);
  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst) rd_n);
  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst) !wr |=> $stable(status));
  // R8
  count_midline_chk: assert property (@(posedge clk) disable iff (rst) (wr && data != 8'h0A) |=> $stable(status));
  // R4
  byte_code_chk: assert property (@(posedge clk) disable iff (rst) wr |-> (data == 8'h0A || (data >= 8'h30 && data <= 8'h39)));
endmodule

bind bcd_line_streamer bcd_line_streamer_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/sim_bcd_line_streamer.sv
module sim_bcd_line_streamer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txe_n = 1'b1;
  logic wr, rd_n;
  logic [7:0] data, status;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bcd_line_streamer #(.DIGITS(2)) u0 (
    .clk(clk), .rst(rst), .txe_n(txe_n), .wr(wr), .rd_n(rd_n),
    .data(data), .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd2(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] exp_byte(input int v, input int idx);
    if (idx == 0) return 8'h30 + 8'(v / 10);
    if (idx == 1) return 8'h30 + 8'(v % 10);
    return 8'h0A;
  endfunction

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lines = 0;
    int bidx = 0;
    logic prev_wr = 1'b0;
    logic drv = 1'b1;
    logic [7:0] lfsr = 8'hA5;
    int cyc = 0;
    int v;

    repeat (3) @(negedge clk);
    check(wr == 1'b0, "R1 wr", {7'd0, wr}, 8'h00);
    check(status == 8'h00, "R1 status", status, 8'h00);
    check(data == 8'h30, "R1 data", data, 8'h30);
    check(rd_n == 1'b1, "R7 rd_n", {7'd0, rd_n}, 8'h01);
    rst = 1'b0;
    drv = 1'b0;
    txe_n = drv;

    while (lines < 230) begin
      @(negedge clk);
      cyc++;
      check(rd_n == 1'b1, "R7 rd_n", {7'd0, rd_n}, 8'h01);
      if (prev_wr)
        check(wr == 1'b0, "R5 strobe width", {7'd0, wr}, 8'h00);
      else if (drv)
        check(wr == 1'b0, "R5 blocked", {7'd0, wr}, 8'h00);
      else
        check(wr == 1'b1, "R6 ready", {7'd0, wr}, 8'h01);
      v = lines % 100;
      check(status == bcd2(v), "R10 R8 status", status, bcd2(v));
      if (wr) begin
        if (bidx == 0) begin
          check(data == exp_byte(v, 0), "R3 leading digit", data, exp_byte(v, 0));
          if (lines == 100 || lines == 200)
            check(data == 8'h30, "R9 wrap", data, 8'h30);
        end else if (bidx == 1)
          check(data == exp_byte(v, 1), "R4 digit", data, exp_byte(v, 1));
        else
          check(data == 8'h0A, "R2 newline", data, 8'h0A);
        bidx++;
        if (bidx == 3) begin
          bidx = 0;
          lines++;
        end
      end
      prev_wr = wr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (lines < 60) drv = 1'b0;
      else if (lines < 150) drv = lfsr[0];
      else drv = ((cyc % 8) < 5);
      txe_n = drv;
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(status == 8'h00, "R1 status after reset", status, 8'h00);
    check(wr == 1'b0, "R1 wr after reset", {7'd0, wr}, 8'h00);
    check(data == 8'h30, "R1 data after reset", data, 8'h30);
    rst = 1'b0;
    txe_n = 1'b0;
    @(negedge clk);
    check(wr == 1'b1 && data == 8'h30, "R1 first byte after reset", data, 8'h30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule